// File: doc/BRIEF.md
# Integer Register-Immediate Execute Unit

This block runs a small set of 32-bit integer instructions, one per clock. Each instruction word is split into fields and two registers are read from a 32-entry register file. An ALU computes the result, which is written back to the register file on the same rising edge that accepts the instruction. Register-register instructions add, subtract and do a signed set-if-less-than. Register-immediate instructions add a signed immediate, compare against a signed immediate, load an upper half, and OR in a zero-extended lower half. Together, the upper-half load and the OR build any 32-bit constant in two instructions.

A separate debug port reads the register file with one cycle of latency. It is the only way to observe results. Encodings outside the supported set raise a one-cycle illegal flag and change no register.

Top module: `iexec_core`

## Requirements
- R1: With op field [31:26]=0 and func field [5:0]=0x20 (add) or 0x22 (sub), the unit writes rs[25:21] plus or minus rt[20:16] into rd[15:11]. The result wraps modulo 2^32 and overflow is ignored. The shamt bits [10:6] are ignored.
- R2: func 0x22A... see below; slt (op 0, func 0x2A) and slti (op 0x0A) write 1 to the destination when the first operand is less than the second in signed order, and 0 otherwise. slti compares rs with its sign-extended immediate.
- R3: addi (op 0x08) writes rs plus the sign-extended 16-bit immediate [15:0] into rt[20:16]. The immediate covers -32768 to +32767.
- R4: Register 0 always reads as zero. An instruction whose destination is register 0 leaves every register unchanged.
- R5: Any other op/func combination raises illegal_o in the cycle after the edge that accepts it, and writes no register. Legal instructions leave illegal_o low.
- R6: While instr_valid is low, no register changes, whatever is on instr_word.
- R7: lui (op 0x0F) writes the immediate into bits [31:16] of rt and clears bits [15:0].
- R8: ori (op 0x0D) writes rs OR the zero-extended immediate into rt, so bits [31:16] of rs pass through unchanged.
- R9: dbg_data is registered. After an edge it shows the value that register dbg_addr held just before that edge, and a write at the same edge appears one cycle later.
- R10: A synchronous active-high rst clears all registers, dbg_data and illegal_o.
- R11: An instruction accepted on the edge right after another one reads the value that the first instruction wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Accept instr_word on this edge |
| instr_word | input | 32 | Instruction to execute |
| illegal_o | output | 1 | Registered flag for an unsupported encoding |
| dbg_addr | input | 5 | Register index for the debug read |
| dbg_data | output | 32 | Registered debug read data |

## Verification
The bench builds the unit at its default parameters: 32-bit data and 32 registers, so the register field covers all five bits. At this width, results from add and addi wrap at the 0x7FFFFFFF to 0x80000000 boundary. Signed compares can be tested against operands whose top bit is set. An immediate of 0x8000 tells sign extension apart from zero extension. A two-step lui/ori pair checks that the two halves are placed correctly.

// File: rtl/iexec_pkg.sv
package iexec_pkg;

  localparam int INSTR_W   = 32;
  localparam int FIELD_W   = 5;
  localparam int IMM_W     = 16;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_SLTI  = 6'h0A;
  localparam logic [5:0] OPC_ORI   = 6'h0D;
  localparam logic [5:0] OPC_LUI   = 6'h0F;

  localparam logic [5:0] FN_ADD    = 6'h20;
  localparam logic [5:0] FN_SUB    = 6'h22;
  localparam logic [5:0] FN_SLT    = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_SLT,
    ALU_OR,
    ALU_UPPER
  } alu_sel_e;

  typedef struct packed {
    logic               legal;
    alu_sel_e           sel;
    logic               use_imm;
    logic               zext_imm;
    logic [FIELD_W-1:0] src_a;
    logic [FIELD_W-1:0] src_b;
    logic [FIELD_W-1:0] dest;
    logic [IMM_W-1:0]   imm;
  } dec_t;

endpackage

// File: rtl/iexec_decode.sv
module iexec_decode
  import iexec_pkg::*;
(
  input  logic [INSTR_W-1:0] word,
  output dec_t               dec
);

  logic [5:0] opc;
  logic [5:0] fn;

  assign opc = word[31:26];
  assign fn  = word[5:0];

  always_comb begin
    dec          = '0;
    dec.src_a    = word[25:21];
    dec.src_b    = word[20:16];
    dec.imm      = word[15:0];
    dec.dest     = word[20:16];
    dec.sel      = ALU_ADD;
    unique case (opc)
      OPC_RTYPE: begin
        dec.dest = word[15:11];
        unique case (fn)
          FN_ADD:  begin dec.legal = 1'b1; dec.sel = ALU_ADD; end
          FN_SUB:  begin dec.legal = 1'b1; dec.sel = ALU_SUB; end
          FN_SLT:  begin dec.legal = 1'b1; dec.sel = ALU_SLT; end
          default: dec.legal = 1'b0;
        endcase
      end
      OPC_ADDI: begin
        dec.legal   = 1'b1;
        dec.sel     = ALU_ADD;
        dec.use_imm = 1'b1;
      end
      OPC_SLTI: begin
        dec.legal   = 1'b1;
        dec.sel     = ALU_SLT;
        dec.use_imm = 1'b1;
      end
      OPC_ORI: begin
        dec.legal    = 1'b1;
        dec.sel      = ALU_OR;
        dec.use_imm  = 1'b1;
        dec.zext_imm = 1'b1;
      end
      OPC_LUI: begin
        dec.legal    = 1'b1;
        dec.sel      = ALU_UPPER;
        dec.use_imm  = 1'b1;
        dec.zext_imm = 1'b1;
      end
      default: dec.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/iexec_alu.sv
module iexec_alu
  import iexec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_sel_e        sel,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic [XLEN-1:0] res
);

  localparam int LOW_W = XLEN - IMM_W;

  always_comb begin
    unique case (sel)
      ALU_ADD:   res = opa + opb;
      ALU_SUB:   res = opa - opb;
      ALU_SLT:   res = ($signed(opa) < $signed(opb)) ? XLEN'(1) : '0;
      ALU_OR:    res = opa | opb;
      ALU_UPPER: res = {opb[IMM_W-1:0], {LOW_W{1'b0}}};
      default:   res = '0;
    endcase
  end

endmodule

// File: rtl/iexec_regfile.sv
module iexec_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [$clog2(NREG)-1:0] wr_addr,
  input  logic [XLEN-1:0]         wr_data,
  input  logic [$clog2(NREG)-1:0] ra_addr,
  output logic [XLEN-1:0]         ra_data,
  input  logic [$clog2(NREG)-1:0] rb_addr,
  output logic [XLEN-1:0]         rb_data,
  input  logic [$clog2(NREG)-1:0] dbg_addr,
  output logic [XLEN-1:0]         dbg_data
);

  localparam int AW = $clog2(NREG);

  logic [NREG-1:0][XLEN-1:0] mem;

  for (genvar g = 0; g < NREG; g++) begin : g_entry
    if (g == 0) begin : g_zero
      assign mem[g] = '0;
    end else begin : g_reg
      logic [XLEN-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) begin
          q <= '0;
        end else if (wr_en && wr_addr == AW'(g)) begin
          q <= wr_data;
        end
      end
      assign mem[g] = q;
    end
  end

  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_data <= '0;
    end else begin
      dbg_data <= mem[dbg_addr];
    end
  end

  // R4: a write aimed at entry 0 changes nothing
  a_r4_zero_write_dropped: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == '0) |=> $stable(mem));

  // R6: no write enable, no change
  a_r6_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(mem));

  // R10: the cycle after a reset edge every entry is zero
  a_r10_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (mem == '0 && dbg_data == '0));

endmodule

// File: rtl/iexec_core.sv
module iexec_core
  import iexec_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    instr_valid,
  input  logic [31:0]             instr_word,
  output logic                    illegal_o,
  input  logic [$clog2(NREG)-1:0] dbg_addr,
  output logic [XLEN-1:0]         dbg_data
);

  localparam int AW  = $clog2(NREG);
  localparam int EXT = XLEN - IMM_W;

  dec_t            dec;
  logic [XLEN-1:0] rs_val;
  logic [XLEN-1:0] rt_val;
  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] opb;
  logic [XLEN-1:0] alu_res;
  logic            wr_en;

  iexec_decode u_dec (
    .word (instr_word),
    .dec  (dec)
  );

  assign imm_ext = dec.zext_imm ? {{EXT{1'b0}}, dec.imm}
                                : {{EXT{dec.imm[IMM_W-1]}}, dec.imm};
  assign opb     = dec.use_imm ? imm_ext : rt_val;
  assign wr_en   = instr_valid && dec.legal;

  iexec_alu #(.XLEN(XLEN)) u_alu (
    .sel (dec.sel),
    .opa (rs_val),
    .opb (opb),
    .res (alu_res)
  );

  iexec_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (dec.dest[AW-1:0]),
    .wr_data  (alu_res),
    .ra_addr  (dec.src_a[AW-1:0]),
    .ra_data  (rs_val),
    .rb_addr  (dec.src_b[AW-1:0]),
    .rb_data  (rt_val),
    .dbg_addr (dbg_addr),
    .dbg_data (dbg_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      illegal_o <= 1'b0;
    end else begin
      illegal_o <= instr_valid && !dec.legal;
    end
  end

  // R5: an accepted unsupported word raises the flag one cycle later
  a_r5_illegal_flag: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !dec.legal) |=> illegal_o);

  // R5: legal or absent instructions keep the flag low
  a_r5_flag_quiet: assert property (@(posedge clk) disable iff (rst)
    !(instr_valid && !dec.legal) |=> !illegal_o);

  // R7: the upper-half load leaves the low half clear
  a_r7_upper_low_zero: assert property (@(posedge clk) disable iff (rst)
    (dec.legal && dec.sel == ALU_UPPER) |-> alu_res[EXT-1:0] == '0);

  // R2: the compare result is a single bit
  a_r2_compare_bool: assert property (@(posedge clk) disable iff (rst)
    (dec.legal && dec.sel == ALU_SLT) |-> alu_res[XLEN-1:1] == '0);

endmodule

// File: tb/iexec_core_tb_top.sv
module iexec_core_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic        illegal_o;
  logic [4:0]  dbg_addr = '0;
  logic [31:0] dbg_data;

  int total = 0;
  int bad   = 0;

  logic [31:0] mdl [32];
  bit          exp_q [$];

  always #5 clk = ~clk;

  iexec_core dut_i (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .instr_word  (instr_word),
    .illegal_o   (illegal_o),
    .dbg_addr    (dbg_addr),
    .dbg_data    (dbg_data)
  );

  function automatic logic [31:0] rtype(input logic [5:0] fn, input int rs, input int rt, input int rd);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'h03, fn};
  endfunction

  function automatic logic [31:0] itype(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model built from the requirement text; returns 1 if legal
  function automatic bit model_exec(input logic [31:0] w);
    logic [5:0]  op = w[31:26];
    logic [5:0]  fn = w[5:0];
    logic [31:0] a  = mdl[w[25:21]];
    logic [31:0] b  = mdl[w[20:16]];
    logic [31:0] se = {{16{w[15]}}, w[15:0]};
    logic [31:0] ze = {16'h0, w[15:0]};
    logic [31:0] r  = '0;
    int          d  = w[20:16];
    bit          ok = 1'b1;
    case (op)
      6'h00: begin
        d = w[15:11];
        case (fn)
          6'h20: r = a + b;
          6'h22: r = a - b;
          6'h2A: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default: ok = 1'b0;
        endcase
      end
      6'h08: r = a + se;
      6'h0A: r = ($signed(a) < $signed(se)) ? 32'd1 : 32'd0;
      6'h0D: r = a | ze;
      6'h0F: r = {w[15:0], 16'h0};
      default: ok = 1'b0;
    endcase
    if (ok && d != 0) mdl[d] = r;
    return ok;
  endfunction

  // driver: presents one word per call, back-to-back when called in a row
  task automatic issue(input logic [31:0] w);
    bit ok;
    @(negedge clk);
    instr_word  = w;
    instr_valid = 1'b1;
    ok = model_exec(w);
    exp_q.push_back(!ok);
  endtask

  task automatic rd_reg(input int idx, input string tag);
    @(negedge clk);
    instr_valid = 1'b0;
    dbg_addr    = 5'(idx);
    @(negedge clk);
    check(tag, dbg_data, mdl[idx]);
  endtask

  // monitor: compares the illegal flag for every accepted instruction
  initial begin
    forever begin
      @(posedge clk);
      if (instr_valid && !rst) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          check("R5 unexpected item", 32'd1, 32'd0);
        end else begin
          check("R5 illegal flag", {31'd0, illegal_o}, {31'd0, exp_q.pop_front()});
        end
      end
    end
  end

  initial begin
    #200us;
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] old;
    foreach (mdl[i]) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    check("R10 illegal after reset", {31'd0, illegal_o}, 32'd0);
    rd_reg(5, "R10 reg after reset");

    // R3 signed immediates, R11 back-to-back dependency
    issue(itype(6'h08, 0, 1, 16'd2000));
    issue(itype(6'h08, 0, 2, 16'hFFFB));
    issue(rtype(6'h20, 1, 2, 3));          // R11: uses r2 written one edge earlier
    rd_reg(1, "R3 addi positive");
    rd_reg(2, "R3 addi negative");
    rd_reg(3, "R11 forward add");
    check("R3 addi literal", mdl[2], 32'hFFFFFFFB);

    // R1 add/sub with wrap
    issue(rtype(6'h22, 2, 1, 4));
    issue(itype(6'h0F, 0, 5, 16'h7FFF));
    issue(itype(6'h0D, 5, 5, 16'hFFFF));
    issue(itype(6'h08, 5, 6, 16'd1));
    issue(rtype(6'h20, 6, 6, 14));
    rd_reg(4, "R1 sub");
    rd_reg(5, "R8 ori fills low half");
    rd_reg(6, "R1 add wraps");
    rd_reg(14, "R1 add wraps to zero");
    check("R1 wrap literal", mdl[6], 32'h80000000);

    // R2 signed compares
    issue(rtype(6'h2A, 2, 1, 7));
    issue(rtype(6'h2A, 1, 2, 8));
    issue(itype(6'h0A, 2, 9, 16'hFFFC));
    issue(itype(6'h0A, 6, 10, 16'h0000));
    issue(itype(6'h0A, 1, 15, 16'd2000));
    rd_reg(7, "R2 slt true");
    rd_reg(8, "R2 slt false");
    rd_reg(9, "R2 slti negative imm");
    rd_reg(10, "R2 slti most negative");
    rd_reg(15, "R2 slti equal");

    // R7 / R8 two-step constant and zero extension
    issue(itype(6'h0F, 0, 11, 16'h003D));
    rd_reg(11, "R7 upper load");
    issue(itype(6'h0D, 11, 11, 16'd2304));
    issue(itype(6'h0D, 0, 12, 16'h8000));
    rd_reg(11, "R8 two-step constant");
    rd_reg(12, "R8 zero extension");
    check("R8 literal", mdl[11], 32'h003D0900);

    // R4 register zero
    issue(itype(6'h08, 0, 0, 16'd77));
    issue(rtype(6'h20, 0, 1, 13));
    rd_reg(0, "R4 reg0 reads zero");
    rd_reg(13, "R4 reg0 as source");

    // R5 illegal encodings write nothing
    issue(itype(6'h23, 0, 1, 16'h1234));
    issue(rtype(6'h00, 1, 1, 3));
    issue(rtype(6'h21, 1, 1, 4));
    rd_reg(1, "R5 illegal op no write");
    rd_reg(3, "R5 illegal func no write");
    rd_reg(4, "R5 near func no write");

    // R6 valid low ignored
    @(negedge clk);
    instr_valid = 1'b0;
    instr_word  = itype(6'h08, 0, 1, 16'd99);
    repeat (2) @(negedge clk);
    rd_reg(1, "R6 valid low ignored");

    // R9 same-edge debug read returns pre-write value
    old = mdl[12];
    @(negedge clk);
    dbg_addr = 5'd12;
    issue(itype(6'h08, 0, 12, 16'd555));
    @(negedge clk);
    instr_valid = 1'b0;
    check("R9 same-edge old value", dbg_data, old);
    @(negedge clk);
    check("R9 next cycle new value", dbg_data, mdl[12]);

    // R10 reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    foreach (mdl[i]) mdl[i] = '0;
    check("R10 dbg cleared", dbg_data, 32'd0);
    rd_reg(1, "R10 reg1 cleared");
    rd_reg(11, "R10 reg11 cleared");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check("R5 pending items", 32'(exp_q.size()), 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule